// File: doc/BRIEF.md
# Load/Store Effective Address Generator

This block computes the memory address for a single-register load or store and the value the base register takes afterwards. A request names a base register in a small shadow register file and supplies the offset. The offset is either a zero-extended immediate or a second register value passed through a barrel shifter. The request also gives a direction bit that adds or subtracts the offset, an indexing-order bit and a writeback bit.

With pre-indexing, the access goes to the base combined with the offset. The combined value is stored back only when writeback is requested. With post-indexing, the access goes to the untouched base and the base always moves by the offset. Results appear on registered response outputs one cycle after a request is accepted. The shadow base is updated on the accepting edge, so a back-to-back request on the same register sees the new base. A preload port seeds the shadow registers, and a combinational peek port reads them back.

Top module: `ls_addr_gen`

## Requirements
- R1: With `req_use_reg`=0 the offset is `req_imm` zero-extended to 32 bits. With `req_up`=1 it is added to the base and with `req_up`=0 it is subtracted. The register offset, shift type and shift amount have no effect in this case.
- R2: With `req_use_reg`=1 the offset is `req_rm` shifted by `req_shamt` (0..31). The shift type is set by `req_shtype`: 0 = logical left, 1 = logical right, 2 = arithmetic right, 3 = rotate right. An amount of 0 leaves the value unchanged for every type.
- R3: With `req_pre`=1 and `req_wback`=0, `rsp_addr` = base ± offset, `rsp_base_we`=0, and the shadow base keeps its value.
- R4: With `req_pre`=1 and `req_wback`=1, `rsp_addr` = base ± offset, `rsp_base_we`=1, and the shadow base becomes that same address.
- R5: With `req_pre`=0, `rsp_addr` equals the unmodified base and the shadow base becomes base ± offset. `rsp_base_we`=1 whatever `req_wback` holds.
- R6: All address arithmetic is modulo 2^32, and wraparound in either direction is silent.
- R7: After reset `rsp_valid` is 0 and every shadow register reads 0. `rsp_valid` is 1 exactly in the cycle after an accepted request (`req_valid` and `req_ready` both high) and 0 otherwise.
- R8: While `pre_we` is high, `req_ready` is 0. A request presented then is not accepted and does not change the shadow register.
- R9: Consecutive accepted requests on one base register each use the base value left by the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pre_we | input | 1 | Preload write strobe for the shadow registers |
| pre_idx | input | 4 | Preload register index |
| pre_val | input | 32 | Preload value |
| peek_idx | input | 4 | Readback register index |
| peek_val | output | 32 | Readback value (combinational) |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_base_idx | input | 4 | Base register index |
| req_use_reg | input | 1 | 1 = shifted register offset, 0 = immediate |
| req_imm | input | 12 | Unsigned immediate offset |
| req_rm | input | 32 | Register offset value |
| req_shtype | input | 2 | Shift type |
| req_shamt | input | 5 | Shift amount |
| req_up | input | 1 | 1 = add offset, 0 = subtract |
| req_pre | input | 1 | 1 = pre-indexed, 0 = post-indexed |
| req_wback | input | 1 | Writeback flag for pre-indexed form |
| rsp_valid | output | 1 | Response outputs valid |
| rsp_addr | output | 32 | Memory access address |
| rsp_new_base | output | 32 | Updated base value |
| rsp_base_we | output | 1 | Base register is written |

## Verification
The hardest situation to reach is a shadow register read and updated on the same edge by consecutive requests. A stale read would still give plausible addresses. The bench sends three post-indexed requests in adjacent cycles to one register and checks each address and the final peeked base. Wraparound and a request collided with a preload are also driven directly. Each vector preloads its own base so the expected values stay independent.

// File: rtl/ls_agen_pkg.sv
package ls_agen_pkg;
   typedef enum logic [1:0] {
      SH_LSL = 2'd0,
      SH_LSR = 2'd1,
      SH_ASR = 2'd2,
      SH_ROR = 2'd3
   } shift_kind_e;
endpackage

// File: rtl/ls_offset_shift.sv
module ls_offset_shift #(
   parameter int DATA_W  = 32,
   parameter int SHAMT_W = 5
) (
   input  logic [DATA_W-1:0]  val_i,
   input  logic [1:0]         kind_i,
   input  logic [SHAMT_W-1:0] amt_i,
   output logic [DATA_W-1:0]  val_o
);
   import ls_agen_pkg::*;

   if (DATA_W != (1 << SHAMT_W)) begin : g_bad_width
      $error("ls_offset_shift: DATA_W must equal 2**SHAMT_W");
   end

   shift_kind_e             kind;
   logic [2*DATA_W-1:0]     rot_dbl;
   logic [DATA_W-1:0]       lsl_v, lsr_v, asr_v, ror_v;

   assign kind    = shift_kind_e'(kind_i);
   assign lsl_v   = val_i << amt_i;
   assign lsr_v   = val_i >> amt_i;
   assign asr_v   = $unsigned($signed(val_i) >>> amt_i);
   assign rot_dbl = {val_i, val_i} >> amt_i;
   assign ror_v   = rot_dbl[DATA_W-1:0];

   always_comb begin
      unique case (kind)
         SH_LSL:  val_o = lsl_v;
         SH_LSR:  val_o = lsr_v;
         SH_ASR:  val_o = asr_v;
         default: val_o = ror_v;
      endcase
   end
endmodule

// File: rtl/ls_ea_calc.sv
module ls_ea_calc #(
   parameter int DATA_W  = 32,
   parameter int IMM_W   = 12,
   parameter int SHAMT_W = 5
) (
   input  logic [DATA_W-1:0]  base_i,
   input  logic               use_reg_i,
   input  logic [IMM_W-1:0]   imm_i,
   input  logic [DATA_W-1:0]  rm_i,
   input  logic [1:0]         shtype_i,
   input  logic [SHAMT_W-1:0] shamt_i,
   input  logic               up_i,
   input  logic               pre_i,
   input  logic               wback_i,
   output logic [DATA_W-1:0]  addr_o,
   output logic [DATA_W-1:0]  new_base_o,
   output logic               base_we_o
);
   if (IMM_W > DATA_W) begin : g_bad_imm
      $error("ls_ea_calc: IMM_W must not exceed DATA_W");
   end

   logic [DATA_W-1:0] shifted, offset, moved;

   ls_offset_shift #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W)) u_shift (
      .val_i  (rm_i),
      .kind_i (shtype_i),
      .amt_i  (shamt_i),
      .val_o  (shifted)
   );

   assign offset     = use_reg_i ? shifted : DATA_W'(imm_i);
   assign moved      = up_i ? (base_i + offset) : (base_i - offset);
   assign addr_o     = pre_i ? moved : base_i;
   assign new_base_o = moved;
   assign base_we_o  = pre_i ? wback_i : 1'b1;
endmodule

// File: rtl/ls_base_shadow.sv
module ls_base_shadow #(
   parameter int DATA_W = 32,
   parameter int NREGS  = 16,
   localparam int IDX_W = $clog2(NREGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pre_we_i,
   input  logic [IDX_W-1:0]  pre_idx_i,
   input  logic [DATA_W-1:0] pre_val_i,
   input  logic              upd_we_i,
   input  logic [IDX_W-1:0]  upd_idx_i,
   input  logic [DATA_W-1:0] upd_val_i,
   input  logic [IDX_W-1:0]  rd_idx_i,
   output logic [DATA_W-1:0] rd_val_o,
   input  logic [IDX_W-1:0]  peek_idx_i,
   output logic [DATA_W-1:0] peek_val_o
);
   if (NREGS < 2 || (1 << IDX_W) != NREGS) begin : g_bad_depth
      $error("ls_base_shadow: NREGS must be a power of two >= 2");
   end

   logic [DATA_W-1:0] regs [NREGS];

   for (genvar i = 0; i < NREGS; i++) begin : g_entry
      always_ff @(posedge clk) begin
         if (!rst_n)
            regs[i] <= '0;
         else if (pre_we_i && pre_idx_i == IDX_W'(i))
            regs[i] <= pre_val_i;
         else if (upd_we_i && upd_idx_i == IDX_W'(i))
            regs[i] <= upd_val_i;
      end
   end

   assign rd_val_o   = regs[rd_idx_i];
   assign peek_val_o = regs[peek_idx_i];
endmodule

// File: rtl/ls_addr_gen.sv
module ls_addr_gen #(
   parameter int DATA_W  = 32,
   parameter int IMM_W   = 12,
   parameter int SHAMT_W = 5,
   parameter int NREGS   = 16,
   localparam int IDX_W  = $clog2(NREGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pre_we,
   input  logic [IDX_W-1:0]  pre_idx,
   input  logic [DATA_W-1:0] pre_val,
   input  logic [IDX_W-1:0]  peek_idx,
   output logic [DATA_W-1:0] peek_val,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [IDX_W-1:0]  req_base_idx,
   input  logic              req_use_reg,
   input  logic [IMM_W-1:0]  req_imm,
   input  logic [DATA_W-1:0] req_rm,
   input  logic [1:0]        req_shtype,
   input  logic [SHAMT_W-1:0] req_shamt,
   input  logic              req_up,
   input  logic              req_pre,
   input  logic              req_wback,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_addr,
   output logic [DATA_W-1:0] rsp_new_base,
   output logic              rsp_base_we
);
   logic              accept;
   logic [DATA_W-1:0] base_val, ea_addr, ea_new_base;
   logic              ea_we;

   assign req_ready = ~pre_we;
   assign accept    = req_valid & req_ready;

   ls_base_shadow #(.DATA_W(DATA_W), .NREGS(NREGS)) u_shadow (
      .clk        (clk),
      .rst_n      (rst_n),
      .pre_we_i   (pre_we),
      .pre_idx_i  (pre_idx),
      .pre_val_i  (pre_val),
      .upd_we_i   (accept & ea_we),
      .upd_idx_i  (req_base_idx),
      .upd_val_i  (ea_new_base),
      .rd_idx_i   (req_base_idx),
      .rd_val_o   (base_val),
      .peek_idx_i (peek_idx),
      .peek_val_o (peek_val)
   );

   ls_ea_calc #(.DATA_W(DATA_W), .IMM_W(IMM_W), .SHAMT_W(SHAMT_W)) u_calc (
      .base_i     (base_val),
      .use_reg_i  (req_use_reg),
      .imm_i      (req_imm),
      .rm_i       (req_rm),
      .shtype_i   (req_shtype),
      .shamt_i    (req_shamt),
      .up_i       (req_up),
      .pre_i      (req_pre),
      .wback_i    (req_wback),
      .addr_o     (ea_addr),
      .new_base_o (ea_new_base),
      .base_we_o  (ea_we)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid    <= 1'b0;
         rsp_addr     <= '0;
         rsp_new_base <= '0;
         rsp_base_we  <= 1'b0;
      end else begin
         rsp_valid <= accept;
         if (accept) begin
            rsp_addr     <= ea_addr;
            rsp_new_base <= ea_new_base;
            rsp_base_we  <= ea_we;
         end
      end
   end
endmodule

// File: rtl/ls_addr_gen_chk.sv
module ls_addr_gen_chk #(
   parameter int DATA_W = 32,
   parameter int IMM_W  = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              pre_we,
   input logic              req_valid,
   input logic              req_ready,
   input logic              req_use_reg,
   input logic [IMM_W-1:0]  req_imm,
   input logic              req_up,
   input logic              req_pre,
   input logic              req_wback,
   input logic [DATA_W-1:0] base_val,
   input logic              rsp_valid,
   input logic [DATA_W-1:0] rsp_addr,
   input logic [DATA_W-1:0] rsp_new_base,
   input logic              rsp_base_we
);
   logic acc;
   assign acc = req_valid && req_ready;

   AST_RSP_FOLLOWS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      acc |=> rsp_valid); // R7
   AST_NO_RSP_WITHOUT_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      !acc |=> !rsp_valid); // R7
   AST_READY_LOW_ON_PRELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      pre_we |-> !req_ready); // R8
   AST_IMM_ADD_PRE: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && !req_use_reg && req_up && req_pre) |=>
         rsp_addr == $past(base_val) + DATA_W'($past(req_imm))); // R1
   AST_PRE_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && req_pre && !req_wback) |=> (!rsp_base_we && rsp_addr == rsp_new_base)); // R3
   AST_PRE_WB: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && req_pre && req_wback) |=> (rsp_base_we && rsp_addr == rsp_new_base)); // R4
   AST_POST_ADDR_BASE: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && !req_pre) |=> (rsp_base_we && rsp_addr == $past(base_val))); // R5
endmodule

bind ls_addr_gen ls_addr_gen_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .pre_we       (pre_we),
   .req_valid    (req_valid),
   .req_ready    (req_ready),
   .req_use_reg  (req_use_reg),
   .req_imm      (req_imm),
   .req_up       (req_up),
   .req_pre      (req_pre),
   .req_wback    (req_wback),
   .base_val     (base_val),
   .rsp_valid    (rsp_valid),
   .rsp_addr     (rsp_addr),
   .rsp_new_base (rsp_new_base),
   .rsp_base_we  (rsp_base_we)
);

// File: tb/tb_ls_addr_gen.sv
`timescale 1ns/1ps
module tb_ls_addr_gen;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pre_we = 1'b0;
   logic [3:0]  pre_idx = '0;
   logic [31:0] pre_val = '0;
   logic [3:0]  peek_idx = '0;
   logic [31:0] peek_val;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [3:0]  req_base_idx = '0;
   logic        req_use_reg = 1'b0;
   logic [11:0] req_imm = '0;
   logic [31:0] req_rm = '0;
   logic [1:0]  req_shtype = '0;
   logic [4:0]  req_shamt = '0;
   logic        req_up = 1'b0, req_pre = 1'b0, req_wback = 1'b0;
   logic        rsp_valid, rsp_base_we;
   logic [31:0] rsp_addr, rsp_new_base;

   int tests = 0;
   int fails = 0;

   always #2 clk = ~clk;

   ls_addr_gen dut (.*);

   typedef struct packed {
      logic [31:0] base;
      logic        use_reg;
      logic [11:0] imm;
      logic [31:0] rm;
      logic [1:0]  sh;
      logic [4:0]  amt;
      logic        up, pre, wb;
      logic [31:0] e_addr;
      logic [31:0] e_nb;
      logic        e_we;
   } vec_t;

   localparam int NV = 12;
   localparam vec_t VEC [NV] = '{
      // R1 R3 imm add, pre, no writeback
      '{32'h0000_1000, 1'b0, 12'h00C, 32'h0, 2'd0, 5'd0, 1'b1, 1'b1, 1'b0, 32'h0000_100C, 32'h0000_100C, 1'b0},
      // R4 imm subtract, pre, writeback
      '{32'h0000_0200, 1'b0, 12'h008, 32'h0, 2'd0, 5'd0, 1'b0, 1'b1, 1'b1, 32'h0000_01F8, 32'h0000_01F8, 1'b1},
      // R5 post, wback flag low still writes
      '{32'h0000_0300, 1'b0, 12'h004, 32'h0, 2'd0, 5'd0, 1'b1, 1'b0, 1'b0, 32'h0000_0300, 32'h0000_0304, 1'b1},
      // R2 LSL 2
      '{32'h0000_1000, 1'b1, 12'h000, 32'h3, 2'd0, 5'd2, 1'b1, 1'b1, 1'b0, 32'h0000_100C, 32'h0000_100C, 1'b0},
      // R2 R5 LSL 3 post
      '{32'h0000_2000, 1'b1, 12'h000, 32'h5, 2'd0, 5'd3, 1'b1, 1'b0, 1'b1, 32'h0000_2000, 32'h0000_2028, 1'b1},
      // R2 LSR 4, subtract, writeback
      '{32'h0000_0100, 1'b1, 12'h000, 32'h80, 2'd1, 5'd4, 1'b0, 1'b1, 1'b1, 32'h0000_00F8, 32'h0000_00F8, 1'b1},
      // R2 R6 ASR 4 then wrap to zero
      '{32'h0800_0000, 1'b1, 12'h000, 32'h8000_0000, 2'd2, 5'd4, 1'b1, 1'b1, 1'b0, 32'h0, 32'h0, 1'b0},
      // R2 ROR 4
      '{32'h0, 1'b1, 12'h000, 32'h0000_00F1, 2'd3, 5'd4, 1'b1, 1'b1, 1'b0, 32'h1000_000F, 32'h1000_000F, 1'b0},
      // R2 ROR amount 0 passes through
      '{32'h10, 1'b1, 12'h000, 32'h1234_5678, 2'd3, 5'd0, 1'b1, 1'b1, 1'b0, 32'h1234_5688, 32'h1234_5688, 1'b0},
      // R1 R6 max imm zero-extended, subtract below zero
      '{32'h0, 1'b0, 12'hFFF, 32'h0, 2'd0, 5'd0, 1'b0, 1'b1, 1'b0, 32'hFFFF_F001, 32'hFFFF_F001, 1'b0},
      // R2 R5 ASR amount 0, post subtract
      '{32'h100, 1'b1, 12'h000, 32'hF0, 2'd2, 5'd0, 1'b0, 1'b0, 1'b1, 32'h100, 32'h10, 1'b1},
      // R1 immediate ignores rm and shift
      '{32'h40, 1'b0, 12'h004, 32'hFFFF, 2'd0, 5'd4, 1'b1, 1'b1, 1'b1, 32'h44, 32'h44, 1'b1}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic preload(input logic [3:0] idx, input logic [31:0] v);
      @(negedge clk);
      pre_we = 1'b1; pre_idx = idx; pre_val = v;
      @(negedge clk);
      pre_we = 1'b0;
   endtask

   task automatic set_req(input logic [3:0] idx, input vec_t v);
      req_valid = 1'b1; req_base_idx = idx; req_use_reg = v.use_reg;
      req_imm = v.imm; req_rm = v.rm; req_shtype = v.sh; req_shamt = v.amt;
      req_up = v.up; req_pre = v.pre; req_wback = v.wb;
   endtask

   initial begin
      #(200000 * 4);
      fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R7 reset state
      check("R7 rsp_valid after reset", 32'(rsp_valid), 32'h0);
      peek_idx = 4'd9;
      #0 check("R7 shadow zero after reset", peek_val, 32'h0);

      for (int i = 0; i < NV; i++) begin
         logic [3:0] idx;
         idx = 4'(i);
         preload(idx, VEC[i].base);
         set_req(idx, VEC[i]);
         @(negedge clk);
         req_valid = 1'b0;
         peek_idx = idx;
         #0;
         check($sformatf("R7 vec%0d rsp_valid", i), 32'(rsp_valid), 32'h1);
         check($sformatf("R1-5 vec%0d addr", i), rsp_addr, VEC[i].e_addr);
         check($sformatf("R6 vec%0d new_base", i), rsp_new_base, VEC[i].e_nb);
         check($sformatf("R3 vec%0d base_we", i), 32'(rsp_base_we), 32'(VEC[i].e_we));
         check($sformatf("R4 vec%0d shadow", i), peek_val,
               VEC[i].e_we ? VEC[i].e_nb : VEC[i].base);
         @(negedge clk);
         check($sformatf("R7 vec%0d valid drops", i), 32'(rsp_valid), 32'h0);
      end

      // R8 request during preload is refused and leaves the register alone
      @(negedge clk);
      set_req(4'd14, VEC[2]);
      pre_we = 1'b1; pre_idx = 4'd14; pre_val = 32'h0000_0700;
      #0 check("R8 ready low during preload", 32'(req_ready), 32'h0);
      @(negedge clk);
      pre_we = 1'b0; req_valid = 1'b0; peek_idx = 4'd14;
      #0;
      check("R8 no response for refused request", 32'(rsp_valid), 32'h0);
      check("R8 shadow holds preload value", peek_val, 32'h0000_0700);

      // R9 back-to-back post-increment on one register
      preload(4'd15, 32'h0000_0500);
      set_req(4'd15, VEC[2]);
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         check($sformatf("R9 chained addr %0d", k), rsp_addr, 32'h0000_0500 + 32'(4 * k));
      end
      req_valid = 1'b0;
      peek_idx = 4'd15;
      #0 check("R9 final base", peek_val, 32'h0000_050C);

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule